// File: doc/BRIEF.md
# Biphase Tape Data Codec

This block turns a serial bit stream into a self-clocking biphase line waveform that can be recorded on audio tape. It also recovers the bit stream from a played-back waveform that has already been squared to logic levels. The encoder takes one data bit per bit cell. It XORs that bit with a bit-rate square wave, which is high in the first half of the cell and low in the second. Every cell therefore has a transition at its middle, and that transition ends at the level of the data bit. A transition also appears at the cell boundary when two neighbouring bits are equal.

The decoder has three stages. A two-flop synchronizer and a both-edge detector come first, and the detector produces a short edge pulse. A retriggerable one-shot follows, with a window of three-quarters of a bit. Last is a capture flop. A transition that arrives while the one-shot is idle is a mid-cell transition, so the new line level is latched as the recovered bit. A transition that arrives while the one-shot is running only restarts the window. The recovered output is a plain NRZ level with no bit strobe, meant for a UART that oversamples it. Every time constant is a count of system-clock cycles. The defaults are derived from the clock frequency for a 2400 bit/s line, a 50 µs edge pulse and a 3/4-bit window.

The encoder input is a valid/ready stream. `enc_ready` is high for exactly one cycle at the start of each bit cell, and a bit is taken on the cycle where both `enc_valid` and `enc_ready` are high. The sender may hold `enc_valid` high with a steady `enc_bit` for as long as it likes. The line does not wait for the sender: if `enc_valid` is low in the ready cycle, an idle mark bit (1) is sent in that cell. The decoder output has no back-pressure.

Top module: `tape_biphase_codec`

## Requirements
- R1: Outside reset, `enc_ready` is high for exactly one cycle in every BIT_CYC cycles, on the first cycle of each bit cell. It is low while `rst` is high.
- R2: A bit b accepted at clock edge E drives `enc_line` to the inverse of b after edges E through E+BIT_CYC/2-1, and to b after edges E+BIT_CYC/2 through E+BIT_CYC-1. `enc_line` changes only at cell starts and cell midpoints.
- R3: When `enc_valid` is low in a ready cycle, the cell carries a mark bit (1): `enc_line` is 0 in the first half and 1 in the second.
- R4: While `rst` is high (synchronous), `enc_line`, `dec_data`, `dec_edge` and `enc_ready` are all 0.
- R5: Each change of `dec_line`, rising or falling, makes `dec_edge` high for exactly EDGE_CYC cycles. The pulse starts on the third rising clock edge after the change.
- R6: A `dec_line` change that finds the window timer idle loads the new level into `dec_data` on the third rising clock edge after the change.
- R7: A `dec_line` change that follows the previous change by WIN_CYC cycles or fewer only restarts the window, and `dec_data` keeps its value.
- R8: A `dec_line` change that follows the previous change by WIN_CYC+1 cycles or more is captured, as in R6.
- R9: With `enc_line` looped to `dec_line`, after an initial mark cell the bit sent in a cell starting at edge E is on `dec_data` after edge E+BIT_CYC/2+3. It stays there until after edge E+BIT_CYC+BIT_CYC/2+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid | input | 1 | Encoder input bit is valid |
| enc_bit | input | 1 | Encoder input data bit |
| enc_ready | output | 1 | Encoder takes a bit this cycle (cell start) |
| enc_line | output | 1 | Biphase-coded line output |
| dec_line | input | 1 | Squared playback waveform, asynchronous |
| dec_edge | output | 1 | Edge pulse, EDGE_CYC cycles per line transition |
| dec_data | output | 1 | Recovered NRZ data level |

## Verification
On every cycle, the assertions check the local rules. The ready pulse lasts one cycle. The line moves only at cell starts and midpoints, and an idle cell starts low. Every detected edge starts the pulse and reloads the window. A capture happens only when the timer is idle, and the data flop holds while the timer runs. Only the bench scenarios can show the end-to-end behaviour. These are the exact waveform of every bit in an exhaustive sweep of all 8-bit patterns, and the recovered stream in loopback with its latency. They also cover the exact window boundary, where a spacing of WIN_CYC reloads and WIN_CYC+1 captures, and the exact length of the edge pulse.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  // which half of a bit cell the coding clock is in
  typedef enum logic {HALF_LEAD = 1'b0, HALF_TRAIL = 1'b1} cell_half_e;
  // bit sent when the source has nothing to offer
  localparam logic IDLE_MARK = 1'b1;
  // synchronizer depth in front of the edge detector
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/biphase_enc.sv
module biphase_enc
  import tbc_pkg::*;
#(
  parameter int BIT_CYC = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic line
);
  localparam int HALF = BIT_CYC / 2;
  localparam int CW   = $clog2(BIT_CYC);

  logic [CW-1:0] pos;
  logic          cur_bit;
  logic          nxt_bit;
  logic          at_start;
  cell_half_e    half;

  always_comb begin
    at_start = (pos == '0);
    half     = (pos < CW'(HALF)) ? HALF_LEAD : HALF_TRAIL;
    nxt_bit  = at_start ? (in_valid ? in_bit : IDLE_MARK) : cur_bit;
    in_ready = !rst && at_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      cur_bit <= 1'b0;
      line    <= 1'b0;
    end else begin
      pos     <= (pos == CW'(BIT_CYC - 1)) ? '0 : pos + CW'(1);
      cur_bit <= nxt_bit;
      // coding clock is high in the leading half
      line    <= nxt_bit ^ (half == HALF_LEAD);
    end
  end

  p_ready_once_r1: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  p_line_steady_r2: assert property (@(posedge clk) disable iff (rst)
    (pos != '0 && pos != CW'(HALF)) |=> $stable(line));

  p_idle_mark_r3: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (line == 1'b0));
endmodule

// File: rtl/edge_pulse.sv
module edge_pulse
  import tbc_pkg::*;
#(
  parameter int EDGE_CYC = 61
) (
  input  logic clk,
  input  logic rst,
  input  logic line_async,
  output logic level,
  output logic strobe,
  output logic pulse
);
  localparam int EW = $clog2(EDGE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [EW-1:0]          pcnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_async};
  end

  always_comb begin
    level  = sync_q[SYNC_STAGES-1];
    strobe = level ^ prev_q;
    pulse  = (pcnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pcnt   <= '0;
    end else begin
      prev_q <= level;
      if (strobe)     pcnt <= EW'(EDGE_CYC);
      else if (pulse) pcnt <= pcnt - EW'(1);
    end
  end

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> pulse);

  p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe) |=> (pcnt == EW'(EDGE_CYC)));
endmodule

// File: rtl/window_capture.sv
module window_capture #(
  parameter int WIN_CYC = 384
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic level,
  output logic data
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [WW-1:0] cnt;
  logic          active;

  assign active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      data <= 1'b0;
    end else if (trig) begin
      cnt <= WW'(WIN_CYC);
      if (!active) data <= level;
    end else if (active) begin
      cnt <= cnt - WW'(1);
    end
  end

  p_capture_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (trig && !active) |=> (data == $past(level)));

  p_hold_active_r7: assert property (@(posedge clk) disable iff (rst)
    (trig && active) |=> $stable(data));

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    trig |=> (cnt == WW'(WIN_CYC)));

  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !trig |=> $stable(data));
endmodule

// File: rtl/tape_biphase_codec.sv
module tape_biphase_codec #(
  parameter int CLK_HZ   = 1_228_800,
  parameter int BAUD     = 2400,
  parameter int BIT_CYC  = CLK_HZ / BAUD,
  parameter int EDGE_CYC = CLK_HZ / 20_000,
  parameter int WIN_CYC  = (BIT_CYC * 3) / 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_valid,
  input  logic enc_bit,
  output logic enc_ready,
  output logic enc_line,
  input  logic dec_line,
  output logic dec_edge,
  output logic dec_data
);
  logic lvl;
  logic trig;

  biphase_enc #(.BIT_CYC(BIT_CYC)) u_enc (
    .clk(clk), .rst(rst), .in_valid(enc_valid), .in_bit(enc_bit),
    .in_ready(enc_ready), .line(enc_line)
  );

  edge_pulse #(.EDGE_CYC(EDGE_CYC)) u_edge (
    .clk(clk), .rst(rst), .line_async(dec_line),
    .level(lvl), .strobe(trig), .pulse(dec_edge)
  );

  window_capture #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .trig(trig), .level(lvl), .data(dec_data)
  );

  p_reset_quiet_r4: assert property (@(posedge clk)
    rst |=> (!enc_line && !dec_data && !dec_edge));
endmodule

// File: tb/sim_tape_biphase_codec.sv
module sim_tape_biphase_codec;
  localparam int CLK_PER = 10;
  localparam int BITC = 16;
  localparam int HALF = BITC / 2;
  localparam int EDGC = 3;
  localparam int WINC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_valid = 1'b0;
  logic enc_bit = 1'b0;
  logic drv_line = 1'b0;
  logic loop_en = 1'b0;
  logic enc_ready, enc_line, dec_edge, dec_data;
  logic dec_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign dec_line = loop_en ? enc_line : drv_line;

  always #(CLK_PER / 2) clk = ~clk;

  tape_biphase_codec #(.BIT_CYC(BITC), .EDGE_CYC(EDGC), .WIN_CYC(WINC)) u0 (
    .clk(clk), .rst(rst), .enc_valid(enc_valid), .enc_bit(enc_bit),
    .enc_ready(enc_ready), .enc_line(enc_line), .dec_line(dec_line),
    .dec_edge(dec_edge), .dec_data(dec_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // send one cell; vld=0 means the encoder must insert a mark
  task automatic send_cell(input bit vld, input bit b);
    bit eb;
    while (!enc_ready) step(1);
    enc_valid = vld;
    enc_bit   = b;
    eb = vld ? b : 1'b1;
    for (int k = 0; k < BITC; k++) begin
      step(1);
      if (vld) chk(enc_line == ((k < HALF) ? ~eb : eb), "R2", enc_line, (k < HALF) ? ~eb : eb);
      else     chk(enc_line == ((k < HALF) ? 1'b0 : 1'b1), "R3", enc_line, (k < HALF) ? 0 : 1);
      chk(enc_ready == (k == BITC - 1), "R1", enc_ready, (k == BITC - 1));
      if (k == HALF + 3) chk(dec_data == eb, "R9", dec_data, eb);
    end
  endtask

  initial begin
    @(negedge clk);
    step(3);
    // R4: reset state
    chk(enc_line == 1'b0, "R4", enc_line, 0);
    chk(dec_data == 1'b0, "R4", dec_data, 0);
    chk(dec_edge == 1'b0, "R4", dec_edge, 0);
    chk(enc_ready == 1'b0, "R4", enc_ready, 0);
    rst = 1'b0;
    step(20);

    // decoder driven directly: first change finds timer idle
    drv_line = 1'b1;
    step(1);
    chk(dec_data == 1'b0, "R6", dec_data, 0);
    step(1);
    chk(dec_data == 1'b0, "R6", dec_data, 0);
    chk(dec_edge == 1'b0, "R5", dec_edge, 0);
    step(1);
    chk(dec_data == 1'b1, "R6", dec_data, 1);
    chk(dec_edge == 1'b1, "R5", dec_edge, 1);
    for (int j = 1; j < EDGC; j++) begin
      step(1);
      chk(dec_edge == 1'b1, "R5", dec_edge, 1);
    end
    step(1);
    chk(dec_edge == 1'b0, "R5", dec_edge, 0);
    // gap so far 3+EDGC <= WINC: reload only
    drv_line = 1'b0;
    step(WINC);
    chk(dec_data == 1'b1, "R7", dec_data, 1);
    drv_line = 1'b1;
    step(WINC);
    chk(dec_data == 1'b1, "R7", dec_data, 1);
    drv_line = 1'b0;               // spacing exactly WINC: held
    step(WINC + 1);
    chk(dec_data == 1'b1, "R7", dec_data, 1);
    drv_line = 1'b1;               // spacing WINC+1: captured (same level)
    step(WINC + 1);
    chk(dec_data == 1'b1, "R8", dec_data, 1);
    drv_line = 1'b0;               // spacing WINC+1: captured
    step(3);
    chk(dec_data == 1'b0, "R8", dec_data, 0);
    chk(dec_edge == 1'b1, "R5", dec_edge, 1);

    // loopback run
    rst = 1'b1;
    step(3);
    chk(dec_data == 1'b0, "R4", dec_data, 0);
    loop_en = 1'b1;
    rst = 1'b0;
    for (int c = 0; c < 3; c++) send_cell(1'b0, 1'b0);
    for (int p = 0; p < 256; p++)
      for (int i = 7; i >= 0; i--) send_cell(1'b1, p[i]);
    send_cell(1'b0, 1'b0);
    send_cell(1'b0, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule